// File: doc/BRIEF.md
# Precise Pipeline Exception Controller

This block is the trap-control unit of an in-order, five-stage pipeline (fetch, decode, execute, memory, writeback). Each stage reports, in the same cycle, whether its instruction has raised an exception and gives that instruction's program counter. An external interrupt line is also sampled. The block picks the single event to honour: the oldest faulting instruction in program order, or the interrupt when no stage faults. It then squashes that instruction and everything younger, blocks its side effects, and steers fetch to a fixed handler address.

All of this happens combinationally, in the cycle in which the fault is presented. The saved return address, the cause code and an exception-level flag are registered and appear on the next cycle. The saved address is always the address of the oldest squashed instruction plus four, so a handler applies one uniform correction before returning. A return strobe clears the exception level and sends fetch back to the saved address. While the exception level is set, interrupts are held off. Synchronous exceptions are still taken.

Top module: `precise_exc_ctrl`

## Requirements
- R1: In reset and in the first cycle after it, `epc_o`, `cause_o` and `exl_o` are all zero, and with no fault, interrupt or return presented `flush_o`, `redirect_o`, `rf_kill_o` and `mem_wr_kill_o` are zero.
- R2: In any cycle in which an exception or interrupt is taken, `redirect_o` is 1 and `redirect_pc_o` equals the handler vector, which defaults to 0x80000180.
- R3: When several stages fault together, the oldest one wins, in the order memory, execute, decode, fetch.
- R4: In the cycle after an exception or interrupt is taken, `epc_o` holds the chosen instruction's PC plus 4.
- R5: In the cycle after an event is taken, `cause_o` holds its code: 0 for an undefined opcode, 1 for overflow, 2 for an interrupt, 3 for a system call, 4 for a TLB miss. A decode stage that reports both an undefined opcode and a system call records 0.
- R6: `flush_o` has bit 0 for fetch, bit 1 for decode, bit 2 for execute and bit 3 for memory. When an exception is taken, the winning stage's bit and the bits of every younger stage are 1, and the bits of older stages are 0.
- R7: `rf_kill_o` is 1 whenever the execute-stage instruction is squashed, so an overflowing instruction never writes its destination register.
- R8: `mem_wr_kill_o` is 1 exactly when `mem_store_i` is 1 and the memory-stage instruction is the one taking an exception. It is 0 for younger faults and for interrupts.
- R9: An interrupt with no stage fault and `exl_o` clear is taken at the execute instruction. Fetch, decode and execute are squashed (`flush_o` = 4'b0111), the memory instruction completes, and EPC becomes `ex_pc_i` + 4.
- R10: Taking any event sets `exl_o` on the next cycle. While `exl_o` is 1, an interrupt causes no redirect and no flush and leaves EPC and the cause unchanged.
- R11: `eret_i` with no fault in the same cycle clears `exl_o` on the next cycle, drives `redirect_pc_o` with `epc_o`, and flushes fetch only (`flush_o` = 4'b0001). A fault in the same cycle overrides the return.
- R12: In a cycle with no taken event and no return, EPC, the cause and `exl_o` hold their values, and there is no flush and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_tlb_miss_i | input | 1 | Fetch-stage TLB miss |
| if_pc_i | input | 32 | PC of the fetch-stage instruction |
| id_illegal_i | input | 1 | Decode-stage undefined opcode |
| id_syscall_i | input | 1 | Decode-stage system call |
| id_pc_i | input | 32 | PC of the decode-stage instruction |
| ex_ovf_i | input | 1 | Execute-stage arithmetic overflow |
| ex_pc_i | input | 32 | PC of the execute-stage instruction |
| mem_tlb_miss_i | input | 1 | Memory-stage TLB miss or page fault |
| mem_store_i | input | 1 | Memory-stage instruction is a store |
| mem_pc_i | input | 32 | PC of the memory-stage instruction |
| irq_i | input | 1 | External interrupt request |
| eret_i | input | 1 | Return-from-exception strobe |
| flush_o | output | 4 | Per-stage squash, bit 0 = fetch to bit 3 = memory |
| rf_kill_o | output | 1 | Block the register write of the execute instruction |
| mem_wr_kill_o | output | 1 | Block the memory-stage store |
| redirect_o | output | 1 | Load a new fetch address |
| redirect_pc_o | output | 32 | New fetch address |
| epc_o | output | 32 | Saved return address (PC + 4) |
| cause_o | output | 5 | Code of the last taken event |
| exl_o | output | 1 | Exception level active |

## Verification
The embedded properties watch, on every cycle, the relations that hold at a single edge or across one edge:
- a memory-stage fault always wins and squashes every stage;
- an overflow always blocks its register write;
- a store survives unless its own stage faults;
- a taken event always points fetch at the vector and raises the exception level;
- a masked interrupt does nothing;
- the saved state holds when idle.

Only the bench's scenarios show the rest:
- the full priority order among every mix of simultaneous faults;
- the exact PC-plus-four and cause values recorded;
- the interplay of return with a fault in the same cycle;
- interrupts being re-enabled after a return.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 5;
    localparam int NSTG    = 4;
    localparam int STG_W   = $clog2(NSTG);

    // Stage index doubles as age rank: a higher index is an older instruction.
    typedef enum logic [STG_W-1:0] {
        STG_IF  = 2'd0,
        STG_ID  = 2'd1,
        STG_EX  = 2'd2,
        STG_MEM = 2'd3
    } stage_e;

    typedef enum logic [CAUSE_W-1:0] {
        CS_ILLEGAL = 5'd0,
        CS_OVF     = 5'd1,
        CS_IRQ     = 5'd2,
        CS_SYSCALL = 5'd3,
        CS_TLB     = 5'd4
    } cause_e;

    typedef struct packed {
        logic            valid;
        stage_e          stage;
        cause_e          cause;
        logic [XLEN-1:0] pc;
    } take_t;

    // Squash the given stage and every younger one.
    function automatic logic [NSTG-1:0] squash_mask(stage_e s);
        logic [NSTG-1:0] m;
        for (int i = 0; i < NSTG; i++) begin
            m[i] = (i <= int'(s));
        end
        return m;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            if_tlb_miss_i,
    input  logic [XLEN-1:0] if_pc_i,
    input  logic            id_illegal_i,
    input  logic            id_syscall_i,
    input  logic [XLEN-1:0] id_pc_i,
    input  logic            ex_ovf_i,
    input  logic [XLEN-1:0] ex_pc_i,
    input  logic            mem_tlb_miss_i,
    input  logic [XLEN-1:0] mem_pc_i,
    input  logic            irq_i,
    input  logic            exl_i,
    output take_t           take_o
);

    logic [NSTG-1:0] req;
    cause_e          code [NSTG];
    logic [XLEN-1:0] pcs  [NSTG];

    always_comb begin
        req[STG_IF]   = if_tlb_miss_i;
        code[STG_IF]  = CS_TLB;
        pcs[STG_IF]   = if_pc_i;

        req[STG_ID]   = id_illegal_i | id_syscall_i;
        code[STG_ID]  = id_illegal_i ? CS_ILLEGAL : CS_SYSCALL;
        pcs[STG_ID]   = id_pc_i;

        req[STG_EX]   = ex_ovf_i;
        code[STG_EX]  = CS_OVF;
        pcs[STG_EX]   = ex_pc_i;

        req[STG_MEM]  = mem_tlb_miss_i;
        code[STG_MEM] = CS_TLB;
        pcs[STG_MEM]  = mem_pc_i;
    end

    // Scan from youngest to oldest, so the oldest request overrides.
    always_comb begin
        take_o = '{valid: 1'b0, stage: STG_IF, cause: CS_ILLEGAL, pc: '0};
        for (int i = 0; i < NSTG; i++) begin
            if (req[i]) begin
                take_o.valid = 1'b1;
                take_o.stage = stage_e'(i);
                take_o.cause = code[i];
                take_o.pc    = pcs[i];
            end
        end
        // Interrupt only at a clean boundary: before the execute instruction.
        if (!take_o.valid && irq_i && !exl_i) begin
            take_o.valid = 1'b1;
            take_o.stage = STG_EX;
            take_o.cause = CS_IRQ;
            take_o.pc    = ex_pc_i;
        end
    end

    AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (rst)
        mem_tlb_miss_i |-> (take_o.valid && take_o.stage == STG_MEM)); // R3

    AST_IRQ_MASKED_SEL: assert property (@(posedge clk) disable iff (rst)
        (exl_i && take_o.valid) |-> take_o.cause != CS_IRQ); // R10

endmodule

// File: rtl/exc_flush.sv
module exc_flush
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst,
    input  take_t           take_i,
    input  logic            eret_i,
    input  logic            mem_store_i,
    input  logic            ex_ovf_i,
    input  logic [XLEN-1:0] epc_i,
    output logic [NSTG-1:0] flush_o,
    output logic            rf_kill_o,
    output logic            mem_wr_kill_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o
);

    localparam logic [NSTG-1:0] RET_MASK = NSTG'(1);

    always_comb begin
        if (take_i.valid) begin
            flush_o = squash_mask(take_i.stage);
        end else if (eret_i) begin
            flush_o = RET_MASK;
        end else begin
            flush_o = '0;
        end
    end

    assign rf_kill_o     = flush_o[STG_EX];
    assign mem_wr_kill_o = mem_store_i && take_i.valid && take_i.stage == STG_MEM;
    assign redirect_o    = take_i.valid || eret_i;
    assign redirect_pc_o = take_i.valid ? HANDLER_VEC : epc_i;

    AST_OVF_BLOCKS_WB: assert property (@(posedge clk) disable iff (rst)
        ex_ovf_i |-> rf_kill_o); // R7

    AST_STORE_SURVIVES: assert property (@(posedge clk) disable iff (rst)
        (take_i.valid && take_i.stage != STG_MEM) |-> !mem_wr_kill_o); // R8

    AST_FLUSH_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        (flush_o == 4'b0000 || flush_o == 4'b0001 || flush_o == 4'b0011 ||
         flush_o == 4'b0111 || flush_o == 4'b1111)); // R6

endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  take_t              take_i,
    input  logic               eret_i,
    output logic [XLEN-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               exl_o
);

    localparam logic [XLEN-1:0] LINK_STEP = XLEN'(4);

    logic [XLEN-1:0]    epc_q;
    cause_e             cause_q;
    logic               exl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            cause_q <= CS_ILLEGAL;
            exl_q   <= 1'b0;
        end else if (take_i.valid) begin
            epc_q   <= take_i.pc + LINK_STEP;
            cause_q <= take_i.cause;
            exl_q   <= 1'b1;
        end else if (eret_i) begin
            exl_q   <= 1'b0;
        end
    end

    assign epc_o   = epc_q;
    assign cause_o = cause_q;
    assign exl_o   = exl_q;

    AST_EXL_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        take_i.valid |=> exl_o); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!take_i.valid && !eret_i) |=> ($stable(epc_o) && $stable(cause_o) && $stable(exl_o))); // R12

    AST_RET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!take_i.valid && eret_i) |=> !exl_o); // R11

endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               if_tlb_miss_i,
    input  logic [XLEN-1:0]    if_pc_i,
    input  logic               id_illegal_i,
    input  logic               id_syscall_i,
    input  logic [XLEN-1:0]    id_pc_i,
    input  logic               ex_ovf_i,
    input  logic [XLEN-1:0]    ex_pc_i,
    input  logic               mem_tlb_miss_i,
    input  logic               mem_store_i,
    input  logic [XLEN-1:0]    mem_pc_i,
    input  logic               irq_i,
    input  logic               eret_i,
    output logic [NSTG-1:0]    flush_o,
    output logic               rf_kill_o,
    output logic               mem_wr_kill_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               exl_o
);

    take_t           take;
    logic [XLEN-1:0] epc;
    logic            exl;

    exc_arbiter u_arb (
        .clk            (clk),
        .rst            (rst),
        .if_tlb_miss_i  (if_tlb_miss_i),
        .if_pc_i        (if_pc_i),
        .id_illegal_i   (id_illegal_i),
        .id_syscall_i   (id_syscall_i),
        .id_pc_i        (id_pc_i),
        .ex_ovf_i       (ex_ovf_i),
        .ex_pc_i        (ex_pc_i),
        .mem_tlb_miss_i (mem_tlb_miss_i),
        .mem_pc_i       (mem_pc_i),
        .irq_i          (irq_i),
        .exl_i          (exl),
        .take_o         (take)
    );

    exc_flush #(.HANDLER_VEC(HANDLER_VEC)) u_flush (
        .clk           (clk),
        .rst           (rst),
        .take_i        (take),
        .eret_i        (eret_i),
        .mem_store_i   (mem_store_i),
        .ex_ovf_i      (ex_ovf_i),
        .epc_i         (epc),
        .flush_o       (flush_o),
        .rf_kill_o     (rf_kill_o),
        .mem_wr_kill_o (mem_wr_kill_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o)
    );

    exc_state u_state (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .eret_i  (eret_i),
        .epc_o   (epc),
        .cause_o (cause_o),
        .exl_o   (exl)
    );

    assign epc_o = epc;
    assign exl_o = exl;

    AST_FAULT_VECTORS: assert property (@(posedge clk) disable iff (rst)
        (if_tlb_miss_i || id_illegal_i || id_syscall_i || ex_ovf_i || mem_tlb_miss_i)
        |-> (redirect_o && redirect_pc_o == HANDLER_VEC)); // R2

    AST_IRQ_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        (exl_o && irq_i && !eret_i && !if_tlb_miss_i && !id_illegal_i && !id_syscall_i &&
         !ex_ovf_i && !mem_tlb_miss_i) |-> (!redirect_o && flush_o == '0)); // R10

endmodule

// File: tb/test_precise_exc_ctrl.sv
`timescale 1ns/1ps
module test_precise_exc_ctrl;

    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        if_tlb = 0, id_ill = 0, id_sys = 0, ex_ovf = 0, mem_tlb = 0, mem_st = 0;
    logic        irq = 0, eret = 0;
    logic [31:0] if_pc = 0, id_pc = 0, ex_pc = 0, mem_pc = 0;
    logic [3:0]  flush;
    logic        rf_kill, mem_wr_kill, redirect, exl;
    logic [31:0] redirect_pc, epc;
    logic [4:0]  cause;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    logic [31:0] m_epc = 0;
    logic [4:0]  m_cause = 0;
    logic        m_exl = 0;

    always #2.5 clk = ~clk;

    precise_exc_ctrl #(.HANDLER_VEC(VEC)) i_precise_exc_ctrl (
        .clk(clk), .rst(rst),
        .if_tlb_miss_i(if_tlb), .if_pc_i(if_pc),
        .id_illegal_i(id_ill), .id_syscall_i(id_sys), .id_pc_i(id_pc),
        .ex_ovf_i(ex_ovf), .ex_pc_i(ex_pc),
        .mem_tlb_miss_i(mem_tlb), .mem_store_i(mem_st), .mem_pc_i(mem_pc),
        .irq_i(irq), .eret_i(eret),
        .flush_o(flush), .rf_kill_o(rf_kill), .mem_wr_kill_o(mem_wr_kill),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc),
        .epc_o(epc), .cause_o(cause), .exl_o(exl)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural expectation for the present inputs.
    task automatic expect_now(output int stg, output logic [4:0] cs, output logic [31:0] pc);
        stg = -1; cs = 0; pc = 0;
        if (mem_tlb)          begin stg = 3; cs = 4; pc = mem_pc; end
        else if (ex_ovf)      begin stg = 2; cs = 1; pc = ex_pc;  end
        else if (id_ill)      begin stg = 1; cs = 0; pc = id_pc;  end
        else if (id_sys)      begin stg = 1; cs = 3; pc = id_pc;  end
        else if (if_tlb)      begin stg = 0; cs = 4; pc = if_pc;  end
        else if (irq && !m_exl) begin stg = 2; cs = 2; pc = ex_pc; end
    endtask

    // Inputs are already applied; compare, then advance one clock.
    task automatic step(input string tag);
        int          stg;
        logic [4:0]  cs;
        logic [31:0] pc;
        logic [3:0]  e_fl;
        #1;
        expect_now(stg, cs, pc);
        e_fl = (stg >= 0) ? 4'((1 << (stg + 1)) - 1) : (eret ? 4'b0001 : 4'b0000);
        chk({tag, " R6"}, "flush", 32'(flush), 32'(e_fl));
        chk({tag, " R2"}, "redirect", 32'(redirect), 32'((stg >= 0) || eret));
        if (stg >= 0 || eret)
            chk({tag, " R2"}, "redirect_pc", redirect_pc, (stg >= 0) ? VEC : m_epc);
        chk({tag, " R7"}, "rf_kill", 32'(rf_kill), 32'(e_fl[2]));
        chk({tag, " R8"}, "mem_wr_kill", 32'(mem_wr_kill), 32'(mem_st && stg == 3));
        chk({tag, " R4"}, "epc", epc, m_epc);
        chk({tag, " R5"}, "cause", 32'(cause), 32'(m_cause));
        chk({tag, " R10"}, "exl", 32'(exl), 32'(m_exl));
        @(posedge clk);
        if (stg >= 0) begin
            m_epc = pc + 32'd4; m_cause = cs; m_exl = 1'b1;
        end else if (eret) begin
            m_exl = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        if_tlb = 0; id_ill = 0; id_sys = 0; ex_ovf = 0; mem_tlb = 0; mem_st = 0;
        irq = 0; eret = 0;
    endtask

    task automatic pcs(input logic [31:0] base);
        mem_pc = base; ex_pc = base + 4; id_pc = base + 8; if_pc = base + 12;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 50000);
        n_bad++;
        $display("FAIL R12 watchdog expired at %0t", $time);
        summary();
    end

    initial begin
        idle(); pcs(32'h0000_1000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "epc in reset", epc, 0);
        chk("R1", "exl in reset", 32'(exl), 0);
        rst = 1'b0;
        step("R1 idle after reset");
        step("R12 idle hold");

        // R5/R6 each single fault
        pcs(32'h0000_2000); if_tlb = 1; step("R5 fetch TLB"); idle();
        chk("R4", "epc fetch", epc, 32'h0000_2010);
        eret = 1; step("R11 return"); idle();
        pcs(32'h0000_3000); id_ill = 1; id_sys = 1; step("R5 illegal beats syscall"); idle();
        chk("R5", "cause illegal", 32'(cause), 0);
        id_sys = 1; step("R5 syscall nested"); idle();
        chk("R5", "cause syscall", 32'(cause), 3);
        eret = 1; step("R11 return"); idle();
        // R7 overflow in EX, younger fetch fault also present: R3
        pcs(32'h0000_4000); ex_ovf = 1; if_tlb = 1; mem_st = 1; step("R3 R7 overflow over fetch"); idle();
        chk("R4", "epc overflow", epc, 32'h0000_4008);
        eret = 1; step("R11"); idle();
        // R3 R8 memory fault with store, plus younger overflow
        pcs(32'h0000_5000); mem_tlb = 1; mem_st = 1; ex_ovf = 1; id_ill = 1;
        step("R3 R8 memory fault wins"); idle();
        chk("R4", "epc mem", epc, 32'h0000_5004);
        chk("R5", "cause tlb", 32'(cause), 4);
        // R10 interrupt masked while exl
        irq = 1; step("R10 irq masked"); step("R10 irq masked again"); idle();
        // R11 return with fault in same cycle: fault wins
        pcs(32'h0000_6000); eret = 1; id_sys = 1; step("R11 fault overrides return"); idle();
        chk("R11", "exl stays", 32'(exl), 1);
        eret = 1; step("R11 return"); idle();
        chk("R11", "exl cleared", 32'(exl), 0);
        // R9 interrupt
        pcs(32'h0000_7000); irq = 1; mem_st = 1; step("R9 interrupt"); idle();
        chk("R9", "epc irq", epc, 32'h0000_7008);
        chk("R9", "cause irq", 32'(cause), 2);
        eret = 1; step("R11"); idle();
        // R9 interrupt with fault: fault wins
        irq = 1; id_ill = 1; step("R9 fault beats irq"); idle();
        eret = 1; step("R11"); idle();
        step("R12 idle");

        // Mixed traffic
        for (int k = 0; k < 3000; k++) begin
            pcs($urandom);
            if_tlb  = ($urandom_range(0, 9) == 0);
            id_ill  = ($urandom_range(0, 11) == 0);
            id_sys  = ($urandom_range(0, 11) == 0);
            ex_ovf  = ($urandom_range(0, 9) == 0);
            mem_tlb = ($urandom_range(0, 11) == 0);
            mem_st  = ($urandom_range(0, 2) == 0);
            irq     = ($urandom_range(0, 5) == 0);
            eret    = ($urandom_range(0, 4) == 0);
            step("R3 R12 mixed");
        end
        idle();
        step("R12 final idle");
        summary();
    end

endmodule